// File: doc/BRIEF.md
# Programmable FIFO Level Flag Unit

This block sits beside a FIFO's storage and turns the core's word count into three active-low level indications: almost-empty, almost-full and half-full. Two thresholds set where the almost flags trip. The empty threshold is compared directly against the count. The full threshold is measured back from the total capacity.

At master reset, the level on the load input picks the programming method and the default value for both thresholds. A low level picks serial loading and 127. A high level picks word-wide loading and 1023. After that, the thresholds can be reprogrammed. In serial mode they are shifted in one bit per clock. In word-wide mode they are written through the offset data input, alternating between the two. Either way they can be read back, in the same alternating order, on the offset output.

A partial reset clears the flags, the readback output and the alternation order. It keeps the thresholds and the programming method. Everything runs in the single clock domain of the write side.

Top module: `fifo_level_flags`

## Requirements
- R1: When `mrst` is high at a clock edge, that edge latches the method and defaults. `ofs_ld` = 0 selects serial programming with both thresholds at 127. `ofs_ld` = 1 selects word-wide programming with both thresholds at 1023.
- R2: At the clock edge where `mrst` or `prst` is high, `pae_n`, `paf_n` and `hf_n` are set high, `ofs_rd_vld` is set low and `ofs_q` is set to zero.
- R3: Outside reset, `pae_n` is registered. It is low after an edge exactly when the `count` sampled at that edge was below the empty threshold.
- R4: Outside reset, `paf_n` is registered. It is low after an edge exactly when the sampled `count` was greater than 2**DEPTH_LOG2 minus the full threshold. A threshold of zero never trips the flag.
- R5: Outside reset, `hf_n` is registered. It is low after an edge exactly when the sampled `count` was greater than 2**(DEPTH_LOG2-1).
- R6: In serial mode, each edge with `ser_en` high shifts `ser_in` into a 2*OFS_W-bit chain, least significant bit first. After 2*OFS_W shifts, the first OFS_W bits form the empty threshold and the next OFS_W bits form the full threshold.
- R7: In word-wide mode, an edge with `ofs_ld` and `wr_en` both high stores `ofs_wdata`. Writes alternate between the two thresholds, starting with the empty threshold.
- R8: An edge with `ofs_ld` and `rd_en` both high puts a threshold on `ofs_q` with `ofs_rd_vld` high for one cycle. Reads alternate empty, then full, in either mode. At other edges `ofs_rd_vld` is low and `ofs_q` holds.
- R9: `prst` leaves the thresholds and the programming method unchanged. It returns both the write alternation and the read alternation to the empty threshold.
- R10: In serial mode, word-wide writes have no effect. In word-wide mode, `ser_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| ofs_ld | input | 1 | Method/default select during master reset; threshold access enable after it |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial threshold bit |
| wr_en | input | 1 | Write enable for word-wide threshold load |
| rd_en | input | 1 | Read enable for threshold readback |
| ofs_wdata | input | OFS_W | Threshold word for word-wide load |
| count | input | DEPTH_LOG2+1 | Stored word count from the FIFO core |
| ofs_q | output | OFS_W | Threshold readback value |
| ofs_rd_vld | output | 1 | Readback value valid this cycle |
| pae_n | output | 1 | Almost-empty, active low |
| paf_n | output | 1 | Almost-full, active low |
| hf_n | output | 1 | Half-full, active low |

## Verification
The bench steps the count through every value from empty to full capacity under several threshold pairs:
- both defaults;
- mid-range thresholds loaded serially;
- the extremes zero and all-ones, loaded serially and by word.

Each sweep locates both flag edges exactly. This separates less-than from less-or-equal, and capacity-minus-offset from offset. Readback after each load separates the empty and full halves of the serial chain and the order of word writes. Writes in the mode that does not use them, and partial resets in the middle of an alternation, show whether state is disturbed or kept.

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
  parameter int DEPTH_LOG2 = 12,
  parameter int OFS_W      = 12,
  parameter int DEF_SMALL  = 127,
  parameter int DEF_LARGE  = 1023
) (
  input  logic                  clk,
  input  logic                  mrst,
  input  logic                  prst,
  input  logic                  ofs_ld,
  input  logic                  ser_en,
  input  logic                  ser_in,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [OFS_W-1:0]      ofs_wdata,
  input  logic [DEPTH_LOG2:0]   count,
  output logic [OFS_W-1:0]      ofs_q,
  output logic                  ofs_rd_vld,
  output logic                  pae_n,
  output logic                  paf_n,
  output logic                  hf_n
);
  localparam int CNT_W = DEPTH_LOG2 + 1;
  localparam int CMP_W = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 1;
  localparam int CAP   = 1 << DEPTH_LOG2;
  localparam logic [OFS_W-1:0] DEF_S = OFS_W'(DEF_SMALL);
  localparam logic [OFS_W-1:0] DEF_L = OFS_W'(DEF_LARGE);
  localparam logic [CMP_W-1:0] CAP_X  = CMP_W'(CAP);
  localparam logic [CMP_W-1:0] HALF_X = CMP_W'(CAP / 2);

  logic [OFS_W-1:0] n_q, m_q;
  logic             par_q, wsel_q, rsel_q;
  logic [CMP_W-1:0] cnt_x, n_x, m_x;

  assign cnt_x = CMP_W'(count);
  assign n_x   = CMP_W'(n_q);
  assign m_x   = CMP_W'(m_q);

  wire ser_shift = !par_q && ser_en;
  wire par_write = par_q && ofs_ld && wr_en;
  wire rd_req    = ofs_ld && rd_en;

  always_ff @(posedge clk) begin
    if (mrst) begin
      par_q      <= ofs_ld;
      n_q        <= ofs_ld ? DEF_L : DEF_S;
      m_q        <= ofs_ld ? DEF_L : DEF_S;
      wsel_q     <= 1'b0;
      rsel_q     <= 1'b0;
      ofs_q      <= '0;
      ofs_rd_vld <= 1'b0;
      pae_n      <= 1'b1;
      paf_n      <= 1'b1;
      hf_n       <= 1'b1;
    end else if (prst) begin
      wsel_q     <= 1'b0;
      rsel_q     <= 1'b0;
      ofs_q      <= '0;
      ofs_rd_vld <= 1'b0;
      pae_n      <= 1'b1;
      paf_n      <= 1'b1;
      hf_n       <= 1'b1;
    end else begin
      if (ser_shift)
        {m_q, n_q} <= {ser_in, m_q, n_q[OFS_W-1:1]};
      if (par_write) begin
        if (wsel_q) m_q <= ofs_wdata;
        else        n_q <= ofs_wdata;
        wsel_q <= ~wsel_q;
      end
      if (rd_req) begin
        ofs_q  <= rsel_q ? m_q : n_q;
        rsel_q <= ~rsel_q;
      end
      ofs_rd_vld <= rd_req;
      pae_n <= !(cnt_x < n_x);
      paf_n <= !(cnt_x + m_x > CAP_X);
      hf_n  <= !(cnt_x > HALF_X);
    end
  end

  // R2
  flags_after_reset_chk: assert property (@(posedge clk) disable iff (mrst || prst)
    $past(mrst || prst) |-> (pae_n && paf_n && hf_n && !ofs_rd_vld));

  // R3
  pae_level_chk: assert property (@(posedge clk) disable iff (mrst || prst)
    !pae_n |-> ($past(cnt_x) < $past(n_x)));

  // R4
  paf_level_chk: assert property (@(posedge clk) disable iff (mrst || prst)
    !paf_n |-> ($past(cnt_x) + $past(m_x) > CAP_X));

  // R5
  hf_level_chk: assert property (@(posedge clk) disable iff (mrst || prst)
    !hf_n |-> ($past(cnt_x) > HALF_X));

  // R8
  rd_vld_chk: assert property (@(posedge clk) disable iff (mrst || prst)
    $past(rd_req && !mrst && !prst) |-> ofs_rd_vld);

  // R10
  ser_ignore_chk: assert property (@(posedge clk) disable iff (mrst)
    $past(!mrst && par_q && !(ofs_ld && wr_en)) |-> $stable({m_q, n_q}));
endmodule

// File: tb/fifo_level_flags_tb.sv
module fifo_level_flags_tb;
  localparam int DL  = 11;
  localparam int OW  = 11;
  localparam int CAP = 1 << DL;

  logic clk = 1'b0;
  logic mrst = 1'b1, prst = 1'b0, ofs_ld = 1'b0, ser_en = 1'b0, ser_in = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [OW-1:0] ofs_wdata = '0;
  logic [DL:0]   count = '0;
  logic [OW-1:0] ofs_q;
  logic ofs_rd_vld, pae_n, paf_n, hf_n;
  int vectors = 0, errs = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fifo_level_flags #(.DEPTH_LOG2(DL), .OFS_W(OW)) u_dut (
    .clk(clk), .mrst(mrst), .prst(prst), .ofs_ld(ofs_ld), .ser_en(ser_en),
    .ser_in(ser_in), .wr_en(wr_en), .rd_en(rd_en), .ofs_wdata(ofs_wdata),
    .count(count), .ofs_q(ofs_q), .ofs_rd_vld(ofs_rd_vld),
    .pae_n(pae_n), .paf_n(paf_n), .hf_n(hf_n));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_flags_chk(string req);
    chk({req, " pae_n"}, pae_n, 1);
    chk({req, " paf_n"}, paf_n, 1);
    chk({req, " hf_n"}, hf_n, 1);
    chk({req, " vld"}, ofs_rd_vld, 0);
    chk({req, " q"}, ofs_q, 0);
  endtask

  task automatic do_mrst(logic sel);
    mrst = 1'b1; ofs_ld = sel;
    tick();
    reset_flags_chk("R2 mrst");
    mrst = 1'b0; ofs_ld = 1'b0;
  endtask

  task automatic do_prst();
    prst = 1'b1;
    tick();
    reset_flags_chk("R2 prst");
    prst = 1'b0;
  endtask

  task automatic readback(string req, int exp);
    ofs_ld = 1'b1; rd_en = 1'b1;
    tick();
    ofs_ld = 1'b0; rd_en = 1'b0;
    chk({req, " R8 vld"}, ofs_rd_vld, 1);
    chk({req, " R8 value"}, ofs_q, exp);
    tick();
    chk("R8 vld drop", ofs_rd_vld, 0);
    chk("R8 hold", ofs_q, exp);
  endtask

  task automatic pwrite(int v);
    ofs_ld = 1'b1; wr_en = 1'b1; ofs_wdata = OW'(v);
    tick();
    ofs_ld = 1'b0; wr_en = 1'b0;
  endtask

  task automatic ser_load(int n, int m);
    for (int i = 0; i < 2 * OW; i++) begin
      ser_en = 1'b1;
      ser_in = (i < OW) ? n[i] : m[i - OW];
      tick();
    end
    ser_en = 1'b0;
  endtask

  task automatic sweep(int n, int m);
    for (int c = 0; c <= CAP; c++) begin
      count = (DL+1)'(c);
      tick();
      chk("R3 pae_n", pae_n, (c < n) ? 0 : 1);
      chk("R4 paf_n", paf_n, (c > CAP - m) ? 0 : 1);
      chk("R5 hf_n", hf_n, (c > CAP / 2) ? 0 : 1);
    end
    count = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    #1;
    tick();
    do_mrst(1'b0);
    readback("R1 small n", 127);
    readback("R1 small m", 127);
    sweep(127, 127);

    pwrite(5);
    pwrite(6);
    readback("R10 par ignored n", 127);
    readback("R10 par ignored m", 127);

    ser_load(300, 1500);
    readback("R6 ser n", 300);
    readback("R6 ser m", 1500);
    sweep(300, 1500);

    ser_load(0, 2047);
    readback("R6 ser n0", 0);
    readback("R6 ser mmax", 2047);
    sweep(0, 2047);

    do_prst();
    readback("R9 ser kept n", 0);
    readback("R9 ser kept m", 2047);

    do_mrst(1'b1);
    readback("R1 large n", 1023);
    readback("R1 large m", 1023);
    sweep(1023, 1023);

    pwrite(2047);
    pwrite(0);
    readback("R7 par n", 2047);
    readback("R7 par m", 0);
    sweep(2047, 0);

    for (int i = 0; i < 30; i++) begin
      ser_en = 1'b1; ser_in = i[0];
      tick();
    end
    ser_en = 1'b0;
    readback("R10 ser ignored n", 2047);
    readback("R10 ser ignored m", 0);

    pwrite(10);
    do_prst();
    pwrite(20);
    readback("R9 wr seq n", 20);
    do_prst();
    readback("R9 rd seq n", 20);
    readback("R9 kept m", 0);
    ser_load(1, 1);
    readback("R9 mode kept n", 20);
    readback("R9 mode kept m", 0);
    sweep(20, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule